// File: doc/BRIEF.md
# Audio Codec Register-Script Initializer

This block brings up an external audio codec after reset. It plays a fixed command script over a two-wire I2C bus, acting as a bit-level master with open-drain SCL and SDA. The script sits in a small ROM that is computed inside the module. Each ROM entry is one of four kinds: a single-register write, a continuation byte that extends the previous write as an auto-increment burst, a wait measured in milliseconds, or an end marker.

Every write is addressed to the codec at 7-bit address 0x18. The block checks the acknowledge after each byte. It raises `done` when it reaches the end of the script. If the codec leaves SDA high in an acknowledge slot, it sends a STOP, raises `error` and stops. A one-cycle `start` pulse given while `done` or `error` is high plays the script again from its first entry. A parameter selects the PLL coefficients for a 12 MHz or a 16 MHz codec master clock.

Top module: `codec_script_init`

## Requirements
- R1: While reset is held, both `scl_oe` and `sda_oe` are 0, so the lines are released. After reset is released the script starts without any `start` pulse.
- R2: Every transaction starts with address byte 0x30 (0x18 shifted left, write bit 0), then a register index, then one or more data bytes. The block releases SDA in every ninth clock slot so the slave can acknowledge.
- R3: The full acknowledged byte stream follows the script in order. It begins with page select (register 0x00 ← 0x00) and software reset (0x01 ← 0x01). It sets master mode (0x08 ← 0xC0) and I2S 16-bit format (0x09 ← 0x00). It powers the outputs up muted (0x33 ← 0x01, 0x41 ← 0x01). The last two writes unmute them (0x33 ← 0x09, then 0x41 ← 0x09). There are 27 transactions and 82 bytes.
- R4: Between the STOP of the software-reset write and the next START there are at least 100 × `MS_CYCLES` clock cycles.
- R5: The PLL P (0x03), J (0x04) and D (0x05/0x06) writes all come before the enable write (0x03 ← 0x81). D is sent as one four-byte transaction (0x30, 0x05, high byte, low byte) with no STOP between its two data bytes.
- R6: With `MCLK_16M` = 0 the J and D bytes are 0x20, 0x1E, 0x00. With `MCLK_16M` = 1 they are 0x18, 0x16, 0x80. P is 0x01 in both cases.
- R7: SDA falls while SCL is high only to form a START, and rises while SCL is high only to form a STOP. Every transaction is bracketed by one START and one STOP.
- R8: On a not-acknowledged byte the block finishes the byte, sends a STOP, sets `error` (with `done` at 0) and issues no further START.
- R9: After the end entry `done` is 1, `busy` is 0 and both lines are released. `done` and `error` are never 1 together.
- R10: A `start` pulse while `done` or `error` is high clears the flags and replays the whole script from its first entry.
- R11: Each SCL high pulse inside a byte lasts 2 × QTR clock cycles, where QTR = `CLK_HZ` / (4 × `SCL_HZ`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Replays the script when idle in done or error |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Script is running |
| done | output | 1 | Script finished with every byte acknowledged |
| error | output | 1 | Script halted on a missing acknowledge |

## Verification
Some properties are checked on every cycle: SDA may move under a high SCL only in the START and STOP phases, `done` and `error` are never high together, both lines are released while idle, `error` holds until a restart, and a rising `error` always follows a STOP. The bench's scenarios cover what those checks cannot see. They capture the acknowledged byte stream and compare it with the script, including the PLL ordering, the four-byte D burst and the final unmutes. They also measure the wait after the software reset and the SCL high width, abort runs with an injected missing acknowledge on the address and the register byte, replay the script with `start`, and compare the 16 MHz coefficient set.

// File: rtl/codec_script_init.sv
module codec_script_init #(
  parameter int          CLK_HZ    = 50_000_000,
  parameter int          SCL_HZ    = 100_000,
  parameter int          MS_CYCLES = CLK_HZ / 1000,
  parameter bit          MCLK_16M  = 1'b0,
  parameter logic [6:0]  DEV_ADDR  = 7'h18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic error
);
  localparam int QTR = CLK_HZ / (4 * SCL_HZ);
  localparam int QW  = $clog2(QTR + 1);
  localparam int MW  = $clog2(MS_CYCLES + 1);
  localparam int PW  = 5;

  localparam logic [1:0] OP_WR = 2'd0, OP_BC = 2'd1, OP_DLY = 2'd2, OP_END = 2'd3;

  localparam logic [7:0] PLL_J  = MCLK_16M ? 8'h18 : 8'h20;
  localparam logic [7:0] PLL_DH = MCLK_16M ? 8'h16 : 8'h1E;
  localparam logic [7:0] PLL_DL = MCLK_16M ? 8'h80 : 8'h00;

  typedef enum logic [2:0] {S_FETCH, S_START, S_BIT, S_STOP, S_DELAY, S_DONE, S_ERR} st_t;

  function automatic logic [17:0] rom_at(input logic [PW-1:0] i);
    case (i)
      5'd0:  rom_at = {OP_WR,  8'h00, 8'h00};
      5'd1:  rom_at = {OP_WR,  8'h01, 8'h01};
      5'd2:  rom_at = {OP_DLY, 16'd100};
      5'd3:  rom_at = {OP_WR,  8'h03, 8'h01};
      5'd4:  rom_at = {OP_WR,  8'h04, PLL_J};
      5'd5:  rom_at = {OP_WR,  8'h05, PLL_DH};
      5'd6:  rom_at = {OP_BC,  8'h00, PLL_DL};
      5'd7:  rom_at = {OP_WR,  8'h03, 8'h81};
      5'd8:  rom_at = {OP_WR,  8'h07, 8'h0A};
      5'd9:  rom_at = {OP_WR,  8'h08, 8'hC0};
      5'd10: rom_at = {OP_WR,  8'h09, 8'h00};
      5'd11: rom_at = {OP_WR,  8'h0F, 8'h00};
      5'd12: rom_at = {OP_WR,  8'h10, 8'h00};
      5'd13: rom_at = {OP_WR,  8'h11, 8'h0F};
      5'd14: rom_at = {OP_WR,  8'h12, 8'hF0};
      5'd15: rom_at = {OP_WR,  8'h13, 8'h00};
      5'd16: rom_at = {OP_WR,  8'h16, 8'h00};
      5'd17: rom_at = {OP_WR,  8'h13, 8'h04};
      5'd18: rom_at = {OP_WR,  8'h16, 8'h04};
      5'd19: rom_at = {OP_WR,  8'h25, 8'hE0};
      5'd20: rom_at = {OP_WR,  8'h26, 8'h10};
      5'd21: rom_at = {OP_WR,  8'h2F, 8'h80};
      5'd22: rom_at = {OP_WR,  8'h40, 8'h80};
      5'd23: rom_at = {OP_WR,  8'h33, 8'h01};
      5'd24: rom_at = {OP_WR,  8'h41, 8'h01};
      5'd25: rom_at = {OP_WR,  8'h2B, 8'h00};
      5'd26: rom_at = {OP_WR,  8'h2C, 8'h00};
      5'd27: rom_at = {OP_WR,  8'h33, 8'h09};
      5'd28: rom_at = {OP_WR,  8'h41, 8'h09};
      default: rom_at = {OP_END, 16'h0000};
    endcase
  endfunction

  st_t           st;
  logic [1:0]    ph;
  logic [QW-1:0] div;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic [1:0]    bidx;
  logic [PW-1:0] pc;
  logic [15:0]   dly;
  logic [MW-1:0] mscnt;
  logic          nack, fail;

  wire [17:0] cur  = rom_at(pc);
  wire [17:0] nxt  = rom_at(PW'(pc + 1'b1));
  wire        onbus = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  wire        tick = (div == QW'(QTR - 1));

  assign scl_oe = (st == S_START && ph == 2'd2) || (st == S_BIT && (ph == 2'd0 || ph == 2'd3)) ||
                  (st == S_STOP && ph == 2'd0);
  assign sda_oe = (st == S_START && ph != 2'd0) || (st == S_BIT && bitn != 4'd8 && !sh[7]) ||
                  (st == S_STOP && ph < 2'd2);
  assign done  = (st == S_DONE);
  assign error = (st == S_ERR);
  assign busy  = !(done || error);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH; ph <= '0; div <= '0; bitn <= '0; sh <= '0; bidx <= '0;
      pc <= '0; dly <= '0; mscnt <= '0; nack <= 1'b0; fail <= 1'b0;
    end else begin
      div <= (onbus && !tick) ? div + 1'b1 : '0;
      case (st)
        S_FETCH: begin
          ph <= '0;
          case (cur[17:16])
            OP_WR:  begin st <= S_START; sh <= {DEV_ADDR, 1'b0}; bidx <= '0; bitn <= '0; end
            OP_DLY: begin st <= S_DELAY; dly <= cur[15:0]; mscnt <= '0; end
            OP_BC:  pc <= pc + 1'b1;
            default: st <= S_DONE;
          endcase
        end
        S_START: if (tick) begin
          if (ph == 2'd2) begin ph <= '0; st <= S_BIT; end
          else ph <= ph + 1'b1;
        end
        S_BIT: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd1 && bitn == 4'd8) nack <= sda_in;
          if (ph == 2'd3) begin
            if (bitn != 4'd8) begin
              sh <= {sh[6:0], 1'b0};
              bitn <= bitn + 1'b1;
            end else begin
              bitn <= '0;
              if (nack) begin fail <= 1'b1; st <= S_STOP; end
              else if (bidx == 2'd0) begin sh <= cur[15:8]; bidx <= 2'd1; end
              else if (bidx == 2'd1) begin sh <= cur[7:0];  bidx <= 2'd2; end
              else if (nxt[17:16] == OP_BC) begin pc <= pc + 1'b1; sh <= nxt[7:0]; end
              else begin pc <= pc + 1'b1; st <= S_STOP; end
            end
          end
        end
        S_STOP: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd3) st <= fail ? S_ERR : S_FETCH;
        end
        S_DELAY: begin
          if (dly == '0) begin pc <= pc + 1'b1; st <= S_FETCH; end
          else if (mscnt == MW'(MS_CYCLES - 1)) begin mscnt <= '0; dly <= dly - 1'b1; end
          else mscnt <= mscnt + 1'b1;
        end
        default: if (start) begin pc <= '0; fail <= 1'b0; nack <= 1'b0; st <= S_FETCH; end
      endcase
    end
  end

  a_r7_sda_fall_only_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (st == S_START));
  a_r7_sda_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (st == S_STOP));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!scl_oe && !sda_oe));
  a_r8_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
  a_r8_error_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(st) == S_STOP));
endmodule

// File: tb/codec_script_init_tb_top.sv
module i2c_slave_model (
  input  logic clk,
  input  logic clear,
  input  logic scl,
  input  logic sda,
  input  int   nack_at,
  output logic drv
);
  logic [7:0] bytes [0:127];
  int start_b [0:63];
  int start_t [0:63];
  int stop_t  [0:63];
  int nbytes, nstart, nstop, bidx, cyc, hi_cnt, hi_min, hi_max;
  logic scl_q, sda_q, acking, hi_ok;
  logic [3:0] bitcnt;
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (clear) begin
      nbytes <= 0; nstart <= 0; nstop <= 0; bidx <= 0; cyc <= 0; hi_cnt <= 0;
      hi_min <= 1000000; hi_max <= 0; scl_q <= 1'b1; sda_q <= 1'b1;
      acking <= 1'b0; hi_ok <= 1'b0; bitcnt <= '0; sh <= '0; drv <= 1'b0;
    end else begin
      cyc <= cyc + 1; scl_q <= scl; sda_q <= sda;
      if (scl && scl_q && sda_q && !sda) begin
        if (nstart < 64) begin start_t[nstart] <= cyc; start_b[nstart] <= nbytes; end
        nstart <= nstart + 1; bitcnt <= '0; acking <= 1'b0; hi_ok <= 1'b0;
      end else if (scl && scl_q && !sda_q && sda) begin
        if (nstop < 64) stop_t[nstop] <= cyc;
        nstop <= nstop + 1;
      end else if (scl && !scl_q) begin
        hi_cnt <= 1; hi_ok <= 1'b1;
        if (!acking && bitcnt < 4'd8) begin sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 1'b1; end
      end else if (scl) begin
        hi_cnt <= hi_cnt + 1;
      end else if (!scl && scl_q) begin
        if (hi_ok) begin
          if (hi_cnt < hi_min) hi_min <= hi_cnt;
          if (hi_cnt > hi_max) hi_max <= hi_cnt;
        end
        if (acking) begin acking <= 1'b0; drv <= 1'b0; bitcnt <= '0; end
        else if (bitcnt == 4'd8) begin
          acking <= 1'b1;
          if (bidx != nack_at) begin
            drv <= 1'b1;
            if (nbytes < 128) bytes[nbytes] <= sh;
            nbytes <= nbytes + 1;
          end
          bidx <= bidx + 1;
        end
      end
    end
  end
endmodule

module codec_script_init_tb_top;
  localparam int CLK_HZ = 50_000_000, SCL_HZ = 2_500_000, MSC = 50;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clr = 1'b1;
  int nack_a = -1, nack_b = -1;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_b [0:127];
  int exp_n = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic scl_oe_a, sda_oe_a, busy_a, done_a, err_a, drv_a;
  logic scl_oe_b, sda_oe_b, busy_b, done_b, err_b, drv_b;
  wire scl_a = !scl_oe_a, sda_a = !(sda_oe_a || drv_a);
  wire scl_b = !scl_oe_b, sda_b = !(sda_oe_b || drv_b);

  codec_script_init #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .MS_CYCLES(MSC), .MCLK_16M(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_a),
    .scl_oe(scl_oe_a), .sda_oe(sda_oe_a), .busy(busy_a), .done(done_a), .error(err_a));
  codec_script_init #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .MS_CYCLES(MSC), .MCLK_16M(1'b1)) dut16_i (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .sda_in(sda_b),
    .scl_oe(scl_oe_b), .sda_oe(sda_oe_b), .busy(busy_b), .done(done_b), .error(err_b));
  i2c_slave_model sl_a (.clk(clk), .clear(clr), .scl(scl_a), .sda(sda_a), .nack_at(nack_a), .drv(drv_a));
  i2c_slave_model sl_b (.clk(clk), .clear(clr), .scl(scl_b), .sda(sda_b), .nack_at(nack_b), .drv(drv_b));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic add_w(input logic [7:0] r, input logic [7:0] d);
    exp_b[exp_n] = 8'h30; exp_b[exp_n+1] = r; exp_b[exp_n+2] = d; exp_n += 3;
  endtask

  task automatic build_expected();
    add_w(8'h00, 8'h00); add_w(8'h01, 8'h01); add_w(8'h03, 8'h01); add_w(8'h04, 8'h20);
    add_w(8'h05, 8'h1E); exp_b[exp_n] = 8'h00; exp_n++;
    add_w(8'h03, 8'h81); add_w(8'h07, 8'h0A); add_w(8'h08, 8'hC0); add_w(8'h09, 8'h00);
    add_w(8'h0F, 8'h00); add_w(8'h10, 8'h00); add_w(8'h11, 8'h0F); add_w(8'h12, 8'hF0);
    add_w(8'h13, 8'h00); add_w(8'h16, 8'h00); add_w(8'h13, 8'h04); add_w(8'h16, 8'h04);
    add_w(8'h25, 8'hE0); add_w(8'h26, 8'h10); add_w(8'h2F, 8'h80); add_w(8'h40, 8'h80);
    add_w(8'h33, 8'h01); add_w(8'h41, 8'h01); add_w(8'h2B, 8'h00); add_w(8'h2C, 8'h00);
    add_w(8'h33, 8'h09); add_w(8'h41, 8'h09);
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_a || err_a) break;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_full_stream(input string tag);
    int bad = 0;
    int first_bad = -1;
    chk(sl_a.nbytes == 82, tag, sl_a.nbytes, 82);
    for (int i = 0; i < 82; i++)
      if (sl_a.bytes[i] !== exp_b[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, {tag, " stream mismatch at index"}, first_bad, -1);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(!scl_oe_a && !sda_oe_a, "R1 lines released in reset", {scl_oe_a, sda_oe_a}, 0);
    chk(!done_a && !err_a, "R9 no flags in reset", {done_a, err_a}, 0);
    rst_n = 1'b1; clr = 1'b0;
    repeat (40) @(negedge clk);
    chk(sl_a.nstart == 1, "R1 script starts by itself", sl_a.nstart, 1);
  endtask

  task automatic t_first_run();
    int ok30 = 1;
    int gap;
    wait_end(60000);
    chk(done_a && !err_a && !busy_a, "R9 done after end entry", {done_a, err_a, busy_a}, 3'b100);
    chk(!scl_oe_a && !sda_oe_a, "R9 lines released when done", {scl_oe_a, sda_oe_a}, 0);
    check_full_stream("R3 byte count");
    for (int i = 0; i < 27; i++) if (sl_a.bytes[sl_a.start_b[i]] !== 8'h30) ok30 = 0;
    chk(ok30 == 1, "R2 every transaction opens with 0x30", ok30, 1);
    chk(sl_a.nstart == 27 && sl_a.nstop == 27, "R7 START/STOP per transaction",
        sl_a.nstart * 100 + sl_a.nstop, 2727);
    chk(sl_a.start_b[5] - sl_a.start_b[4] == 4, "R5 D burst is one 4-byte transaction",
        sl_a.start_b[5] - sl_a.start_b[4], 4);
    chk(sl_a.bytes[sl_a.start_b[5]+1] == 8'h03 && sl_a.bytes[sl_a.start_b[5]+2] == 8'h81,
        "R5 PLL enable follows coefficients", sl_a.bytes[sl_a.start_b[5]+2], 8'h81);
    chk(sl_a.bytes[77] == 8'h33 && sl_a.bytes[78] == 8'h09 && sl_a.bytes[80] == 8'h41 &&
        sl_a.bytes[81] == 8'h09, "R3 unmute writes are last", sl_a.bytes[81], 8'h09);
    gap = sl_a.start_t[2] - sl_a.stop_t[1];
    chk(gap >= 100 * MSC && gap <= 100 * MSC + 50, "R4 wait after software reset", gap, 100 * MSC);
    chk(sl_a.hi_min == 10 && sl_a.hi_max == 10, "R11 SCL high width",
        sl_a.hi_min * 100 + sl_a.hi_max, 1010);
    chk(sl_a.bytes[sl_a.start_b[3]+2] == 8'h20 && sl_a.bytes[sl_a.start_b[4]+2] == 8'h1E &&
        sl_a.bytes[sl_a.start_b[4]+3] == 8'h00, "R6 12 MHz coefficients",
        sl_a.bytes[sl_a.start_b[3]+2], 8'h20);
  endtask

  task automatic t_pll16();
    for (int i = 0; i < 5000 && !done_b; i++) @(negedge clk);
    chk(done_b == 1'b1, "R6 16 MHz variant completes", done_b, 1);
    chk(sl_b.nbytes == 82, "R6 16 MHz byte count", sl_b.nbytes, 82);
    chk(sl_b.bytes[sl_b.start_b[2]+2] == 8'h01, "R6 16 MHz P", sl_b.bytes[sl_b.start_b[2]+2], 8'h01);
    chk(sl_b.bytes[sl_b.start_b[3]+2] == 8'h18, "R6 16 MHz J", sl_b.bytes[sl_b.start_b[3]+2], 8'h18);
    chk(sl_b.bytes[sl_b.start_b[4]+2] == 8'h16 && sl_b.bytes[sl_b.start_b[4]+3] == 8'h80,
        "R6 16 MHz D", {sl_b.bytes[sl_b.start_b[4]+2], sl_b.bytes[sl_b.start_b[4]+3]}, 16'h1680);
  endtask

  task automatic t_nack(input int at, input int exp_bytes, input int exp_starts);
    nack_a = at;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    pulse_start();
    wait_end(20000);
    chk(err_a && !done_a, "R8 error on missing acknowledge", {err_a, done_a}, 2'b10);
    chk(sl_a.nstop == exp_starts, "R8 STOP after missing acknowledge", sl_a.nstop, exp_starts);
    repeat (3000) @(negedge clk);
    chk(sl_a.nstart == exp_starts, "R8 no START after error", sl_a.nstart, exp_starts);
    chk(sl_a.nbytes == exp_bytes, "R8 acknowledged bytes before halt", sl_a.nbytes, exp_bytes);
    chk(err_a && !scl_oe_a && !sda_oe_a, "R8 halted with lines released",
        {err_a, scl_oe_a, sda_oe_a}, 3'b100);
  endtask

  task automatic t_rerun();
    nack_a = -1;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    pulse_start();
    @(negedge clk);
    chk(!err_a && busy_a, "R10 start clears error", {err_a, busy_a}, 2'b01);
    wait_end(60000);
    chk(done_a && !err_a, "R10 replay finishes", {done_a, err_a}, 2'b10);
    check_full_stream("R10 replay byte count");
  endtask

  initial begin
    build_expected();
    repeat (3) @(negedge clk);
    t_reset_state();
    t_first_run();
    t_pll16();
    t_nack(4, 4, 2);
    t_nack(0, 0, 1);
    t_rerun();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule